// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 10-bit successive-approximation converter. A microprocessor requests a conversion by driving its active-low select and write strobes low together. The request is captured in a start latch. While both strobes stay low, the latch holds the search logic cleared. Once a strobe goes high, the latch lets go at the next boundary of an internal 8-clock bit slot. From then on, a single token walks down a 10-stage register, one stage per slot, testing the most significant bit first.

During each slot the block drives a trial code toward the DAC side. At the end of the slot it samples a one-bit decision from the comparator model and keeps or drops the bit under test. When the token leaves the last stage, the finished code is loaded into a result latch and a one-cycle transfer strobe is issued for the bus-read logic that sits in a separate block. A new start request during a search abandons that search. A pending-start output tells the interrupt logic to clear its flag.

Top module: `sar_seq_top`

## Requirements
- R1: After the synchronous active-high reset `rst`, `trial_code`, `result`, `xfer`, `busy` and `start_pend` are all 0.
- R2: While `cs_n` and `wr_n` are both low, the sequencer is held: from the clock after they are sampled low, `trial_code` is 0 and `busy` is 1, however many cycles the hold lasts.
- R3: A strobe pattern with only one of `cs_n`/`wr_n` low never starts a conversion, so `busy` stays 0 from idle.
- R4: After at least one strobe returns high, the first trial code (only the MSB set, value 512) appears between 1 and 8 clocks later, aligned to the free-running 8-clock slot.
- R5: Bits are tried MSB first. Each bit occupies 8 clocks, and during that slot `trial_code` equals the bits already decided with the bit under test forced to 1.
- R6: At the end of a slot, the bit under test is kept when `cmp_ge` is 1 (input at or above the trial level) and cleared otherwise, so the final code equals the input value in straight binary.
- R7: The clock after the last bit is decided, `xfer` is high for exactly one cycle, 80 clocks after the first trial code appears. `result` loads the final code at that point and changes at no other time.
- R8: An input at or above full scale gives 1023 (all ones), and a comparator that always reports 0 (negative input) gives 0.
- R9: A new start (both strobes low) during a search abandons it: `trial_code` goes to 0, no `xfer` is issued, `result` keeps its old value, and a fresh search follows the release.
- R10: `start_pend` is 1 from the clock after both strobes are sampled low until the slot boundary at which the sequencer is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cs_n | input | 1 | Active-low chip select strobe |
| wr_n | input | 1 | Active-low write strobe |
| cmp_ge | input | 1 | Comparator decision: input at or above trial level |
| trial_code | output | 10 | Trial code driven to the DAC side |
| result | output | 10 | Latched final conversion code |
| xfer | output | 1 | One-cycle strobe when `result` is loaded |
| busy | output | 1 | Start pending or search running |
| start_pend | output | 1 | Start latch state, used to clear the interrupt flag |

## Verification
The hardest situation to reach from the ports is the release timing against the hidden 8-clock slot counter. The delay from strobe release to the first trial depends on a phase that the bench cannot set directly. The stimulus therefore inserts different idle gaps before each start, which lands the release on different slot phases, and it checks every observed latency against the 1-to-8 window. An abort is reached by re-asserting both strobes in the middle of a search. Release with only the write strobe rising, while select stays low, covers the other way out of the held state.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int unsigned CODE_W_DEF = 10;
  localparam int unsigned PH_W_DEF   = 3;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_HELD  = 2'd1,
    SQ_TRIAL = 2'd2
  } sq_mode_e;
endpackage

// File: rtl/sar_phase_gen.sv
module sar_phase_gen #(
  parameter int unsigned PH_W = 3
) (
  input  logic clk,
  input  logic rst,
  output logic slot_end
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  assign slot_end = (phase_q == PH_LAST);
endmodule

// File: rtl/sar_start_latch.sv
module sar_start_latch (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic slot_end,
  output logic req_q,
  output logic release_p
);
  // the slot-end pulse only clears the latch once the set condition is gone
  assign release_p = req_q && slot_end && !set_req;

  always_ff @(posedge clk) begin
    if (rst)            req_q <= 1'b0;
    else if (set_req)   req_q <= 1'b1;
    else if (release_p) req_q <= 1'b0;
  end
endmodule

// File: rtl/sar_trial_core.sv
module sar_trial_core #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold,
  input  logic         load,
  input  logic         slot_end,
  input  logic         ge,
  output logic [N-1:0] tok,
  output logic [N-1:0] code,
  output logic [N-1:0] code_next,
  output logic         done
);
  localparam logic [N-1:0] MSB_ONE = {1'b1, {(N-1){1'b0}}};

  function automatic logic [N-1:0] decide(input logic [N-1:0] c,
                                          input logic [N-1:0] t,
                                          input logic         g);
    return (c & ~t) | (g ? t : '0);
  endfunction

  logic [N-1:0] tok_shift;
  logic         step;

  // token moves one stage toward the LSB per slot
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_stage
      if (gi == N-1) begin : g_top
        assign tok_shift[gi] = 1'b0;
      end else begin : g_mid
        assign tok_shift[gi] = tok[gi+1];
      end
    end
  endgenerate

  assign step      = slot_end && (|tok) && !hold;
  assign code_next = decide(code, tok, ge);
  assign done      = step && tok[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      tok  <= '0;
      code <= '0;
    end else if (load) begin
      tok  <= MSB_ONE;
      code <= '0;
    end else if (hold) begin
      tok  <= '0;
      code <= '0;
    end else if (step) begin
      tok  <= tok_shift;
      code <= code_next;
    end
  end
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top #(
  parameter int unsigned CODE_W = sar_seq_pkg::CODE_W_DEF,
  parameter int unsigned PH_W   = sar_seq_pkg::PH_W_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic              cmp_ge,
  output logic [CODE_W-1:0] trial_code,
  output logic [CODE_W-1:0] result,
  output logic              xfer,
  output logic              busy,
  output logic              start_pend
);
  import sar_seq_pkg::*;

  function automatic logic [CODE_W-1:0] trial_of(input logic [CODE_W-1:0] c,
                                                 input logic [CODE_W-1:0] t);
    return c | t;
  endfunction

  logic              set_req;
  logic              hold;
  logic              slot_end;
  logic              req_q;
  logic              release_p;
  logic              done_w;
  logic [CODE_W-1:0] tok_w;
  logic [CODE_W-1:0] code_w;
  logic [CODE_W-1:0] code_next_w;
  sq_mode_e          mode_w;

  assign set_req = !cs_n && !wr_n;
  assign hold    = req_q || set_req;

  sar_phase_gen #(.PH_W(PH_W)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .slot_end (slot_end)
  );

  sar_start_latch u_start (
    .clk       (clk),
    .rst       (rst),
    .set_req   (set_req),
    .slot_end  (slot_end),
    .req_q     (req_q),
    .release_p (release_p)
  );

  sar_trial_core #(.N(CODE_W)) u_core (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .load      (release_p),
    .slot_end  (slot_end),
    .ge        (cmp_ge),
    .tok       (tok_w),
    .code      (code_w),
    .code_next (code_next_w),
    .done      (done_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      xfer   <= 1'b0;
    end else begin
      xfer <= done_w;
      if (done_w) result <= code_next_w;
    end
  end

  assign mode_w     = req_q ? SQ_HELD : ((|tok_w) ? SQ_TRIAL : SQ_IDLE);
  assign trial_code = trial_of(code_w, tok_w);
  assign busy       = req_q || (|tok_w);
  assign start_pend = req_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int unsigned N = 10
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic                 wr_n,
  input logic [N-1:0]         trial_code,
  input logic [N-1:0]         result,
  input logic                 xfer,
  input logic                 busy,
  input logic                 start_pend,
  input logic [N-1:0]         tok,
  input sar_seq_pkg::sq_mode_e mode
);
  localparam logic [N-1:0] MSB_ONE = {1'b1, {(N-1){1'b0}}};

  p_hold_clears_r2: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !wr_n) |=> (start_pend && busy && trial_code == '0));

  p_single_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    (!start_pend && (cs_n || wr_n)) |=> !start_pend);

  p_release_msb_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(start_pend) |-> (busy && trial_code == MSB_ONE));

  p_one_token_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == sar_seq_pkg::SQ_TRIAL) |-> ($countones(tok) == 1));

  p_xfer_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    xfer |=> !xfer);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !xfer |-> $stable(result));

  p_xfer_code_r7: assert property (@(posedge clk) disable iff (rst)
    xfer |-> (result == trial_code));

  p_abort_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !start_pend && !cs_n && !wr_n) |=> (trial_code == '0 && !xfer));
endmodule

bind sar_seq_top sar_seq_chk #(.N(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .wr_n       (wr_n),
  .trial_code (trial_code),
  .result     (result),
  .xfer       (xfer),
  .busy       (busy),
  .start_pend (start_pend),
  .tok        (tok_w),
  .mode       (mode_w)
);

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 10;
  localparam int FULL       = (1 << N) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1;
  logic wr_n = 1'b1;
  int   vin = 0;
  bit   vin_neg = 1'b0;
  logic cmp_ge;
  logic [N-1:0] trial_code, result;
  logic xfer, busy, start_pend;

  // behavioural comparator: input at or above the trial level
  assign cmp_ge = vin_neg ? 1'b0 : (vin >= int'(trial_code));

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_seq_top dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .cmp_ge(cmp_ge),
    .trial_code(trial_code), .result(result), .xfer(xfer),
    .busy(busy), .start_pend(start_pend)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  task automatic check(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: slot counter, start flag, bit index, partial code
  int m_phase = 0, m_req = 0, m_idx = -1, m_code = 0, m_res = 0, m_xfer = 0;

  function automatic int m_trial();
    return (m_idx >= 0) ? (m_code | (1 << m_idx)) : m_code;
  endfunction

  always @(posedge clk) begin : model
    int  tr;
    bit  g;
    bit  st;
    st = !cs_n && !wr_n;
    tr = m_trial();
    g  = vin_neg ? 1'b0 : (vin >= tr);
    if (rst) begin
      m_phase = 0; m_req = 0; m_idx = -1; m_code = 0; m_res = 0; m_xfer = 0;
    end else begin
      m_xfer = 0;
      if (st) begin
        m_req = 1; m_idx = -1; m_code = 0;
      end else if (m_req != 0) begin
        m_code = 0;
        if (m_phase == 7) begin m_req = 0; m_idx = N - 1; end
        else m_idx = -1;
      end else if (m_idx >= 0 && m_phase == 7) begin
        if (g) m_code = m_code | (1 << m_idx);
        if (m_idx == 0) begin m_res = m_code; m_xfer = 1; end
        m_idx = m_idx - 1;
      end
      m_phase = (m_phase + 1) % 8;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 trial_code vs model", int'(trial_code), m_trial());
      check("R7 result vs model", int'(result), m_res);
      check("R7 xfer vs model", int'(xfer), m_xfer);
      check("R2 busy vs model", int'(busy), (m_req != 0 || m_idx >= 0) ? 1 : 0);
      check("R10 start_pend vs model", int'(start_pend), m_req);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  // run one conversion: idle gap, strobe hold, release, wait for transfer
  task automatic run_conv(input int v, input bit neg, input int pre,
                          input int len, input bit keep_cs, input int old_res);
    int lat;
    int cnt;
    int exp;
    vin = v; vin_neg = neg;
    repeat (pre) @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      check("R10 start_pend during hold", int'(start_pend), 1);
      check("R2 trial_code held at 0", int'(trial_code), 0);
      check("R2 busy during hold", int'(busy), 1);
      check("R9 result kept during hold", int'(result), old_res);
    end
    wr_n = 1'b1;
    if (!keep_cs) cs_n = 1'b1;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!(trial_code == 10'd512 && busy && !start_pend) && lat < 20);
    check("R4 release latency within 1..8", (lat >= 1 && lat <= 8) ? 1 : 0, 1);
    cs_n = 1'b1;
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!xfer && cnt < 120);
    check("R7 clocks from first trial to xfer", cnt, 80);
    exp = neg ? 0 : ((v > FULL) ? FULL : v);
    check("R6 final code equals input", int'(result), exp);
    @(negedge clk);
    check("R7 xfer lasts one cycle", int'(xfer), 0);
    check("R7 result held after xfer", int'(result), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 trial_code after reset", int'(trial_code), 0);
    check("R1 result after reset", int'(result), 0);
    check("R1 xfer after reset", int'(xfer), 0);
    check("R1 busy after reset", int'(busy), 0);
    check("R1 start_pend after reset", int'(start_pend), 0);
    rst = 1'b0;

    // R3: one strobe low at a time never starts
    cs_n = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check("R3 select alone", int'(busy), 0);
    end
    cs_n = 1'b1; wr_n = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check("R3 write alone", int'(busy), 0);
    end
    wr_n = 1'b1;
    @(negedge clk);

    run_conv(700, 1'b0, 0, 1, 1'b0, 0);
    run_conv(FULL, 1'b0, 3, 37, 1'b0, 700);     // R2 long hold, R8 full scale
    run_conv(2000, 1'b0, 5, 2, 1'b0, FULL);     // R8 above full scale
    run_conv(0, 1'b0, 1, 1, 1'b1, FULL);        // release via write only
    run_conv(600, 1'b1, 2, 3, 1'b0, 0);         // R8 negative input
    run_conv(512, 1'b0, 6, 1, 1'b0, 0);
    run_conv(511, 1'b0, 7, 4, 1'b1, 512);
    run_conv(1, 1'b0, 4, 1, 1'b0, 511);

    // R9: abort a running search
    vin = 300; vin_neg = 1'b0;
    cs_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
    repeat (45) begin
      @(negedge clk);
      check("R9 no xfer before abort", int'(xfer), 0);
    end
    check("R9 search running before abort", int'(busy), 1);
    run_conv(850, 1'b0, 0, 2, 1'b0, 1);
    repeat (100) begin
      @(negedge clk);
      check("R9 no late xfer from aborted search", int'(xfer), 0);
    end
    check("R9 result from restarted search", int'(result), 850);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule